// File: doc/BRIEF.md
# Time-Sliced Voice Mixer with Shared Parameter Memory

The block produces one mixed audio sample per frame by serving a fixed number of voices in turn. Each voice receives a fixed slot of clock cycles. Within its slot the engine reads the voice's parameter words from a single shared RAM, reads one sample word addressed by the voice's start address plus its running offset, scales the sample by the voice volume and adds it to a mix accumulator. At the end of the slot it writes the advanced offset back. After the last voice, the saturated mix is presented with a one-cycle valid strobe and the accumulator restarts from zero.

A host port shares the same RAM. The engine's per-slot schedule is fixed and always wins the bus. The host is therefore only served in the slot cycles the schedule leaves idle, and it waits on a ready signal until then. Writes of less than a whole word are done as a read, a byte merge and a write, all inside idle cycles.

The slot sequencer is a state machine with five states: FETCH (parameter reads, slot cycles 0..10), SAMPLE (sample read, cycle 11), MIX (accumulate, cycle 12), SPARE (cycles 13..14) and WBACK (offset write, cycle 15). Its transitions are FETCH→SAMPLE after the last parameter read, SAMPLE→MIX, MIX→SPARE, SPARE→WBACK in cycle 14, and WBACK→FETCH for the next voice. The host port has three states: IDLE, MERGE and COMMIT. In IDLE, a granted read or full write completes and the port stays in IDLE, while a granted partial write goes to MERGE. MERGE always goes to COMMIT. COMMIT goes back to IDLE once the merged word is written in an idle cycle.

Top module: `tdm_voice_mixer`

## Requirements
- R1: Voices 0..63 are served in ascending order in 16-cycle slots, and voice 0 follows voice 63. out_valid is high for exactly one cycle every 1024 cycles. The first pulse is high in the cycle that begins 1024 clock edges after reset is released.
- R2: The engine owns the RAM in slot cycles 0..11 (11 parameter reads, then the sample read) and in cycle 15 (offset write). host_ready is asserted only in slot cycles 12, 13 or 14.
- R3: out_sample holds the saturated sum of all 64 voice contributions from the frame just finished. The accumulator is zero when out_valid is high, so no frame carries anything from the previous one.
- R4: Voice v's parameter word k is at RAM word v*32+k. Word 0 has the key-on flag in bit 0 and an unsigned 8-bit volume in bits 15:8. Word 1 holds the start address and word 2 the offset. A sample word carries a signed 16-bit sample in bits 15:0. An active voice contributes floor(sample*volume/256).
- R5: A voice whose key-on flag is 0 adds nothing to the mix and keeps its offset. It still occupies its full slot, so frame timing and host stall pattern are unchanged.
- R6: The 24-bit mix is clamped to the range -32768..32767 when presented.
- R7: The sample of an active voice is read at word (start+offset) mod 4096. Its offset grows by exactly one per frame and is written back in slot cycle 15.
- R8: A host read or full-word write is served in the first idle cycle. A request raised in slot cycle 0 sees host_ready in cycle 12. Read data is on host_rdata in the cycle after host_ready.
- R9: A host write with host_be not all ones changes only the enabled bytes (bit i enables bits 8i+7..8i). It uses a read, a merge cycle and a write, so a request raised in slot cycle 0 sees host_ready in cycle 14.
- R10: While reset is held, out_valid, out_sample and host_ready are 0, even with host_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Byte enables for writes |
| host_rdata | output | 32 | Read data, valid the cycle after host_ready |
| host_ready | output | 1 | Access is performed in this cycle |
| out_sample | output | 16 | Saturated signed mix of the last frame |
| out_valid | output | 1 | One-cycle strobe marking a new out_sample |

## Verification
A mixed value is due on the out_valid pulse that closes the first full frame after the last configuring write. The bench therefore throws away the pulse of the partly configured frame and compares the next one. It counts clock edges from reset and derives the slot phase from that count. With this phase it requires out_valid exactly at multiples of 1024 and host_ready only in phases 12 to 14. Latency checks start a request in phase 0 and expect host_ready in phase 12 for whole-word accesses and in phase 14 for partial writes. Read data is sampled one cycle after host_ready.

// File: rtl/tvm_pkg.sv
package tvm_pkg;
    typedef enum logic [2:0] {
        ENG_FETCH,
        ENG_SAMPLE,
        ENG_MIX,
        ENG_SPARE,
        ENG_WBACK
    } eng_state_t;

    typedef enum logic [1:0] {
        HOST_IDLE,
        HOST_MERGE,
        HOST_COMMIT
    } host_state_t;

    // parameter word indices inside a voice block
    localparam int CTRL_WORD   = 0;
    localparam int START_WORD  = 1;
    localparam int OFFSET_WORD = 2;
    // control word field positions
    localparam int KEY_BIT     = 0;
    localparam int VOL_LSB     = 8;
endpackage

// File: rtl/tvm_shared_ram.sv
module tvm_shared_ram #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // read register keeps its value across write and idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en && !we) begin
            q <= mem[addr];
        end
    end
endmodule

// File: rtl/tvm_slot_seq.sv
module tvm_slot_seq
    import tvm_pkg::*;
#(
    parameter int NUM_VOICES    = 64,
    parameter int SLOT_CYCLES   = 16,
    parameter int PARAM_FETCHES = 11,
    localparam int VB = $clog2(NUM_VOICES),
    localparam int CB = $clog2(SLOT_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CB-1:0] cyc,
    output logic [VB-1:0] voice,
    output eng_state_t    state,
    output logic          eng_busy,
    output logic          frame_end
);
    localparam logic [CB-1:0] LAST_CYC  = CB'(SLOT_CYCLES - 1);
    localparam logic [CB-1:0] LAST_FET  = CB'(PARAM_FETCHES - 1);
    localparam logic [CB-1:0] SPARE_END = CB'(SLOT_CYCLES - 2);
    localparam logic [VB-1:0] LAST_V    = VB'(NUM_VOICES - 1);

    eng_state_t next_state;

    // slot position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc   <= '0;
            voice <= '0;
        end else begin
            cyc <= (cyc == LAST_CYC) ? '0 : cyc + 1'b1;
            if (cyc == LAST_CYC) begin
                voice <= (voice == LAST_V) ? '0 : voice + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_FETCH;
        end else begin
            state <= next_state;
        end
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ENG_FETCH:  if (cyc == LAST_FET) next_state = ENG_SAMPLE;
            ENG_SAMPLE: next_state = ENG_MIX;
            ENG_MIX:    next_state = ENG_SPARE;
            ENG_SPARE:  if (cyc == SPARE_END) next_state = ENG_WBACK;
            ENG_WBACK:  next_state = ENG_FETCH;
            default:    next_state = ENG_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        eng_busy  = 1'b0;
        frame_end = 1'b0;
        unique case (state)
            ENG_FETCH, ENG_SAMPLE: eng_busy = 1'b1;
            ENG_WBACK: begin
                eng_busy  = 1'b1;
                frame_end = (voice == LAST_V);
            end
            ENG_MIX, ENG_SPARE: eng_busy = 1'b0;
            default: eng_busy = 1'b0;
        endcase
    end

    // R1
    voice_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_WBACK) |=> (cyc == '0 &&
            voice == (($past(voice) == LAST_V) ? '0 : $past(voice) + 1'b1)));

    // R2
    wback_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_WBACK) |-> (cyc == LAST_CYC));

    // R2
    sample_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_SAMPLE) |-> (cyc == CB'(PARAM_FETCHES)));
endmodule

// File: rtl/tvm_mix_path.sv
module tvm_mix_path
    import tvm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SMP_W  = 16,
    parameter int VOL_W  = 8,
    parameter int ACC_W  = 24,
    parameter int OUT_W  = 16,
    parameter int CB     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  eng_state_t        state,
    input  logic [CB-1:0]     cyc,
    input  logic              frame_end,
    input  logic [DATA_W-1:0] ram_q,
    output logic [ADDR_W-1:0] sample_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic [OUT_W-1:0]  out_sample,
    output logic              out_valid
);
    localparam int PROD_W = SMP_W + VOL_W + 1;
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

    logic                     key_q;
    logic [VOL_W-1:0]         vol_q;
    logic [ADDR_W-1:0]        start_q;
    logic [DATA_W-1:0]        offset_q;
    logic signed [ACC_W-1:0]  acc;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  contrib;
    logic [OUT_W-1:0]         clamped;

    // parameter capture: data of the read in cycle k is in ram_q at cycle k+1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= 1'b0;
            vol_q    <= '0;
            start_q  <= '0;
            offset_q <= '0;
        end else if (state == ENG_FETCH) begin
            if (cyc == CB'(CTRL_WORD + 1)) begin
                key_q <= ram_q[KEY_BIT];
                vol_q <= ram_q[VOL_LSB +: VOL_W];
            end
            if (cyc == CB'(START_WORD + 1)) begin
                start_q <= ram_q[ADDR_W-1:0];
            end
            if (cyc == CB'(OFFSET_WORD + 1)) begin
                offset_q <= ram_q;
            end
        end
    end

    assign sample_addr = start_q + offset_q[ADDR_W-1:0];
    assign wb_data     = key_q ? offset_q + DATA_W'(1) : offset_q;

    always_comb begin
        prod    = $signed(ram_q[SMP_W-1:0]) * $signed({1'b0, vol_q});
        contrib = ACC_W'(prod >>> VOL_W);
        if (acc > POS_LIM) begin
            clamped = POS_LIM[OUT_W-1:0];
        end else if (acc < NEG_LIM) begin
            clamped = NEG_LIM[OUT_W-1:0];
        end else begin
            clamped = acc[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (frame_end) begin
            acc <= '0;
        end else if (state == ENG_MIX && key_q) begin
            acc <= acc + contrib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= frame_end;
            if (frame_end) begin
                out_sample <= clamped;
            end
        end
    end

    // R3
    acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc == '0));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    silent_voice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_MIX && !key_q) |=> (acc == $past(acc)));
endmodule

// File: rtl/tvm_host_port.sv
module tvm_host_port
    import tvm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int NB = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NB-1:0]     be,
    input  logic              bus_free,
    input  logic [DATA_W-1:0] ram_q,
    output logic              ready,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    host_state_t       state, next_state;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] hold_q;
    logic              partial;

    assign partial  = we && (be != {NB{1'b1}});
    assign mem_addr = addr;

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : ram_q[8*b +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HOST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state == HOST_MERGE) begin
            hold_q <= merged;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            HOST_IDLE:   if (req && bus_free && partial) next_state = HOST_MERGE;
            HOST_MERGE:  next_state = HOST_COMMIT;
            HOST_COMMIT: if (bus_free) next_state = HOST_IDLE;
            default:     next_state = HOST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = wdata;
        unique case (state)
            HOST_IDLE: begin
                if (req && bus_free) begin
                    mem_en = 1'b1;
                    mem_we = we && !partial;
                    ready  = !partial;
                end
            end
            HOST_MERGE: begin
                mem_en = 1'b0;
            end
            HOST_COMMIT: begin
                if (bus_free) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = hold_q;
                    ready     = 1'b1;
                end
            end
            default: mem_en = 1'b0;
        endcase
    end

    // R9
    merge_then_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOST_MERGE) |=> (state == HOST_COMMIT));

    // R9
    commit_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOST_COMMIT) |-> (req && we));
endmodule

// File: rtl/tdm_voice_mixer.sv
module tdm_voice_mixer
    import tvm_pkg::*;
#(
    parameter int NUM_VOICES    = 64,
    parameter int SLOT_CYCLES   = 16,
    parameter int PARAM_FETCHES = 11,
    parameter int PARAM_WORDS   = 32,
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 32,
    parameter int SMP_W         = 16,
    parameter int VOL_W         = 8,
    parameter int ACC_W         = 24,
    parameter int OUT_W         = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [DATA_W/8-1:0] host_be,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_ready,
    output logic [OUT_W-1:0]    out_sample,
    output logic                out_valid
);
    localparam int VB  = $clog2(NUM_VOICES);
    localparam int CB  = $clog2(SLOT_CYCLES);
    localparam int PWB = $clog2(PARAM_WORDS);

    logic [CB-1:0]     cyc;
    logic [VB-1:0]     voice;
    eng_state_t        eng_state;
    logic              eng_busy;
    logic              frame_end;
    logic [ADDR_W-1:0] sample_addr;
    logic [DATA_W-1:0] wb_data;
    logic [ADDR_W-1:0] eng_addr;
    logic              eng_we;
    logic              host_en, host_mem_we;
    logic [ADDR_W-1:0] host_mem_addr;
    logic [DATA_W-1:0] host_mem_wdata;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_q;

    tvm_slot_seq #(
        .NUM_VOICES   (NUM_VOICES),
        .SLOT_CYCLES  (SLOT_CYCLES),
        .PARAM_FETCHES(PARAM_FETCHES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .voice    (voice),
        .state    (eng_state),
        .eng_busy (eng_busy),
        .frame_end(frame_end)
    );

    tvm_mix_path #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SMP_W (SMP_W),
        .VOL_W (VOL_W),
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .CB    (CB)
    ) u_mix (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (eng_state),
        .cyc        (cyc),
        .frame_end  (frame_end),
        .ram_q      (ram_q),
        .sample_addr(sample_addr),
        .wb_data    (wb_data),
        .out_sample (out_sample),
        .out_valid  (out_valid)
    );

    tvm_host_port #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .we       (host_we),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .be       (host_be),
        .bus_free (!eng_busy),
        .ram_q    (ram_q),
        .ready    (host_ready),
        .mem_en   (host_en),
        .mem_we   (host_mem_we),
        .mem_addr (host_mem_addr),
        .mem_wdata(host_mem_wdata)
    );

    // engine address per schedule step
    always_comb begin
        eng_we   = 1'b0;
        eng_addr = ADDR_W'({voice, PWB'(cyc)});
        unique case (eng_state)
            ENG_FETCH:  eng_addr = ADDR_W'({voice, PWB'(cyc)});
            ENG_SAMPLE: eng_addr = sample_addr;
            ENG_WBACK: begin
                eng_addr = ADDR_W'({voice, PWB'(OFFSET_WORD)});
                eng_we   = 1'b1;
            end
            ENG_MIX, ENG_SPARE: eng_we = 1'b0;
            default: eng_we = 1'b0;
        endcase
    end

    // engine has fixed priority on the single RAM port
    always_comb begin
        ram_en    = eng_busy || host_en;
        ram_we    = eng_busy ? eng_we   : host_mem_we;
        ram_addr  = eng_busy ? eng_addr : host_mem_addr;
        ram_wdata = eng_busy ? wb_data  : host_mem_wdata;
    end

    tvm_shared_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ram_en),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(ram_wdata),
        .q    (ram_q)
    );

    assign host_rdata = ram_q;

    // R2
    host_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !eng_busy);

    // R7
    offset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && eng_busy) |-> (cyc == CB'(SLOT_CYCLES - 1)));
endmodule

// File: tb/sim_tdm_voice_mixer.sv
module sim_tdm_voice_mixer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = 4'hF;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic [15:0] out_sample;
    logic        out_valid;

    int edges = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    tdm_voice_mixer u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_rdata(host_rdata), .host_ready(host_ready),
        .out_sample(out_sample), .out_valid(out_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // continuous monitors on the slot phase
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            if (host_ready) begin
                chk("R2 ready only in idle slot cycle",
                    int'((edges % 16) >= 12 && (edges % 16) <= 14), 1);
            end
            if (edges > 0 && (edges % 1024) == 0) begin
                chk("R1 strobe at frame boundary", int'(out_valid), 1);
            end else if (out_valid) begin
                chk("R1 strobe off boundary", edges, -1);
            end
        end
    end

    task automatic host_write(input int addr, input logic [31:0] data,
                              input logic [3:0] be, output int phase);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 12'(addr);
        host_wdata = data; host_be = be;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        phase = edges % 16;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; host_be = 4'hF;
    endtask

    task automatic host_read(input int addr, output logic [31:0] data,
                             output int phase);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 12'(addr);
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        phase = edges % 16;
        @(negedge clk);
        host_req = 1'b0;
        #1;
        data = host_rdata;
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        int ph;
        host_write(addr, data, 4'hF, ph);
    endtask

    // R4 layout: word v*32+k, ctrl = key bit0, volume bits 15:8
    task automatic set_voice(input int v, input bit key, input int vol,
                             input int start, input int off);
        wr(v*32 + 0, {16'h0, 8'(vol), 7'h0, key});
        wr(v*32 + 1, 32'(start));
        wr(v*32 + 2, 32'(off));
    endtask

    task automatic fill(input int base, input int n, input logic [15:0] smp);
        for (int i = 0; i < n; i++) wr(base + i, {16'h0, smp});
    endtask

    task automatic all_voices(input bit key, input int vol, input int start);
        for (int v = 0; v < 64; v++) set_voice(v, key, vol, start, 0);
    endtask

    task automatic wait_frame(output int val);
        do begin @(negedge clk); #1; end while (!out_valid);
        val = int'($signed(out_sample));
    endtask

    task automatic settled_frame(output int val);
        int dummy;
        wait_frame(dummy);
        wait_frame(val);
    endtask

    task automatic align_phase(input int p);
        do @(negedge clk); while ((edges % 16) != p);
    endtask

    task automatic t_reset;
        host_req = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk("R10 out_valid in reset", int'(out_valid), 0);
        chk("R10 out_sample in reset", int'(out_sample), 0);
        chk("R10 host_ready in reset", int'(host_ready), 0);
        host_req = 1'b0;
    endtask

    task automatic t_single;
        int val;
        all_voices(1'b0, 0, 2048);
        fill(2048, 16, 16'd1000);
        set_voice(3, 1'b1, 128, 2048, 0);
        settled_frame(val);
        chk("R4 single voice 1000*128/256", val, 500);
    endtask

    task automatic t_mixed;
        int val;
        fill(2100, 16, 16'hFFFD);
        fill(2150, 16, 16'hFC18);
        set_voice(10, 1'b1, 1, 2100, 0);
        set_voice(20, 1'b1, 64, 2150, 0);
        settled_frame(val);
        chk("R4 three voices with negative floor", val, 249);
        settled_frame(val);
        chk("R3 next frame starts from zero", val, 249);
    endtask

    task automatic t_inactive;
        int val;
        wr(3*32 + 0, {16'h0, 8'd128, 8'h00});
        settled_frame(val);
        chk("R5 key-off voice adds nothing", val, -251);
    endtask

    task automatic t_saturate;
        int val;
        fill(2200, 16, 16'h7FFF);
        all_voices(1'b1, 255, 2200);
        settled_frame(val);
        chk("R6 positive clamp", val, 32767);
        fill(2200, 16, 16'h8000);
        settled_frame(val);
        chk("R6 negative clamp", val, -32768);
        for (int v = 0; v < 64; v++) wr(v*32, 32'h0);
        settled_frame(val);
        chk("R3 accumulator cleared after clamp", val, 0);
    endtask

    task automatic t_offset;
        int ph, val;
        logic [31:0] a, b, a2, b2;
        set_voice(5, 1'b1, 0, 2048, 0);
        set_voice(6, 1'b0, 0, 2048, 7);
        settled_frame(val);
        host_read(5*32 + 2, a, ph);
        host_read(6*32 + 2, b, ph);
        wait_frame(val);
        host_read(5*32 + 2, a2, ph);
        host_read(6*32 + 2, b2, ph);
        chk("R7 active offset +1 per frame", int'(a2 - a), 1);
        chk("R5 inactive offset kept", int'(b2), 7);
        chk("R5 inactive offset kept earlier", int'(b), 7);
    endtask

    task automatic t_host;
        int ph;
        logic [31:0] d;
        align_phase(15);
        host_write(7*32 + 20, 32'h11223344, 4'hF, ph);
        chk("R8 full write latency phase", ph, 12);
        align_phase(15);
        host_read(7*32 + 20, d, ph);
        chk("R8 read latency phase", ph, 12);
        chk("R8 read data", int'(d), 32'h11223344);
        align_phase(15);
        host_write(7*32 + 20, 32'h0000AB00, 4'b0010, ph);
        chk("R9 partial write latency phase", ph, 14);
        host_read(7*32 + 20, d, ph);
        chk("R9 byte merge", int'(d), 32'h1122AB44);
        host_write(7*32 + 20, 32'hBEEF0000, 4'b1100, ph);
        host_read(7*32 + 20, d, ph);
        chk("R9 halfword merge", int'(d), 32'hBEEFAB44);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_host;
        t_single;
        t_mixed;
        t_inactive;
        t_saturate;
        t_offset;
        repeat (4) @(negedge clk);
        finish_run;
    end

    initial begin
        #(CLK_P * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule